// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Run-Time Threshold Flags

This block is a first-in first-out buffer for 9-bit words with independent write and read clocks. A producer writes on its own clock and a consumer reads on another. Four active-low status outputs report the buffer state: empty, full, almost-empty and almost-full. Empty and almost-empty live in the read clock domain. Full and almost-full live in the write clock domain. The binary pointers are converted to Gray code and crossed into the other domain through two-flop synchronizers. Each flag is computed from the local pointer and the synchronized remote pointer, then registered once.

The two almost-thresholds can be set at run time. A load control input redirects both ports away from the data memory to a bank of four 9-bit threshold registers. Each load-mode write stores into the next register in a fixed rotating order. Each load-mode read returns the next register in the same order. The almost-empty threshold is n and the almost-full threshold is m. Both reset to 7. The depth is a parameter with a default of 64 words.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, `empty_n` and `ae_n` are 0, `af_n` and `full_n` are 1, and four load-mode reads return 7, 0, 7, 0 in that order.
- R2: With `load`=0 and `wr_en`=1, each rising `wclk` edge stores `din` into the next threshold register. The order is: position 0 (n low), position 1 (n high), position 2 (m low), position 3 (m high). After position 3 it wraps to position 0. Both sequence positions reset to 0.
- R3: With `wr_en`=0, a `wclk` edge changes neither the data memory nor any threshold register, whatever the level of `load`.
- R4: With `load`=0 and both `rd_en` and `rd_en2` at 1, each rising `rclk` edge puts the next threshold register on `dout`, in the R2 order, wrapping after position 3.
- R5: With `load`=1, writes with `wr_en`=1 enqueue `din`. Reads with `rd_en`=`rd_en2`=1 place the oldest word on `dout` after that `rclk` edge. Words leave in the order they entered.
- R6: A read needs both read enables. With only one of them at 1, `dout`, the read position and the flags are unchanged.
- R7: `ae_n` is 0 when the buffer holds n or fewer words and 1 when it holds n+1 or more. It is updated only by `rclk` edges.
- R8: `af_n` is 0 when the buffer holds DEPTH−m or more words and 1 otherwise. It is updated only by `wclk` edges.
- R9: `empty_n` is 0 exactly when the buffer holds 0 words. `full_n` is 0 exactly when it holds DEPTH words.
- R10: A write while `full_n`=0 is dropped. A read while `empty_n`=0 leaves `dout` and the read position unchanged.
- R11: A threshold equals the low log2(DEPTH) bits of the concatenation {high register, low register}. Higher bits have no effect. At depth 64 this means the high registers never change the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| load | input | 1 | 1: ports access data memory; 0: ports access threshold registers |
| wr_en | input | 1 | Write enable |
| din | input | 9 | Write data |
| rd_en | input | 1 | First read enable |
| rd_en2 | input | 1 | Second read enable; a read needs both |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Low when empty (read domain) |
| ae_n | output | 1 | Low at or below the almost-empty threshold (read domain) |
| af_n | output | 1 | Low at or above the almost-full level (write domain) |
| full_n | output | 1 | Low when full (write domain) |

## Verification
A corrupted write pointer shows up in the read domain a few read clocks later. It appears as an occupancy step that no write explains, which shifts `empty_n` and `ae_n` away from the reference count, or as a word out of order on `dout` at the next read. A stuck or skipped threshold sequence position is visible on the first readback or at the first threshold crossing: the readback word or the flag edge moves by one place. Gating errors around full and empty show up as extra or missing words when the buffer is drained.

// File: rtl/pff_pkg.sv
package pff_pkg;
    // Rotating access order of the threshold bank
    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } thr_sel_e;

    localparam int WORD_W = 9;
endpackage

// File: rtl/pff_sync2.sv
module pff_sync2 #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side
    import pff_pkg::*;
#(
    parameter int         DEPTH   = 64,
    parameter int         W       = 9,
    parameter int         AW      = $clog2(DEPTH),
    parameter int         PW      = AW + 1,
    parameter logic [W-1:0] DEF_THR = 7
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_en,
    input  logic [W-1:0]      din,
    input  logic [PW-1:0]     rgray_sync,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [PW-1:0]     wgray,
    output logic [PW-1:0]     wbin,
    output thr_sel_e          wsel,
    output logic [3:0][W-1:0] thr,
    output logic              full_n,
    output logic              af_n
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        thr_sel_e          sel;
        logic [3:0][W-1:0] thr;
        logic              full_n;
        logic              af_n;
    } wr_state_t;

    wr_state_t s_q, s_d;
    logic [PW-1:0] rbin, used, m_ext;
    logic          mem_go, thr_go;

    always_comb begin
        s_d = s_q;
        rbin[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync[i];

        mem_go = wr_en && load && s_q.full_n;
        thr_go = wr_en && !load;

        if (mem_go) s_d.bin = s_q.bin + 1'b1;
        s_d.gray = s_d.bin ^ (s_d.bin >> 1);

        if (thr_go) begin
            s_d.thr[s_q.sel] = din;
            s_d.sel          = thr_sel_e'(s_q.sel + 2'd1);
        end

        m_ext      = {1'b0, AW'({s_q.thr[SEL_AF_HI], s_q.thr[SEL_AF_LO]})};
        used       = s_d.bin - rbin;
        s_d.full_n = (used != DEPTH_P);
        s_d.af_n   = (used < (DEPTH_P - m_ext));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bin    <= '0;
            s_q.gray   <= '0;
            s_q.sel    <= SEL_AE_LO;
            s_q.thr    <= {{W{1'b0}}, DEF_THR, {W{1'b0}}, DEF_THR};
            s_q.full_n <= 1'b1;
            s_q.af_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we    = mem_go;
    assign mem_waddr = s_q.bin[AW-1:0];
    assign wgray     = s_q.gray;
    assign wbin      = s_q.bin;
    assign wsel      = s_q.sel;
    assign thr       = s_q.thr;
    assign full_n    = s_q.full_n;
    assign af_n      = s_q.af_n;
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side
    import pff_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rd_en,
    input  logic              rd_en2,
    input  logic [PW-1:0]     wgray_sync,
    input  logic [3:0][W-1:0] thr,
    input  logic [W-1:0]      mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [PW-1:0]     rgray,
    output logic [PW-1:0]     rbin,
    output logic [W-1:0]      dout,
    output logic              empty_n,
    output logic              ae_n
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        thr_sel_e      sel;
        logic [W-1:0]  dout;
        logic          empty_n;
        logic          ae_n;
    } rd_state_t;

    rd_state_t s_q, s_d;
    logic [PW-1:0] wbin, used, n_ext;
    logic          rd_go, mem_go, thr_go;

    always_comb begin
        s_d = s_q;
        wbin[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync[i];

        rd_go  = rd_en && rd_en2;
        mem_go = rd_go && load && s_q.empty_n;
        thr_go = rd_go && !load;

        if (mem_go) begin
            s_d.dout = mem_rdata;
            s_d.bin  = s_q.bin + 1'b1;
        end
        if (thr_go) begin
            s_d.dout = thr[s_q.sel];
            s_d.sel  = thr_sel_e'(s_q.sel + 2'd1);
        end
        s_d.gray = s_d.bin ^ (s_d.bin >> 1);

        n_ext       = {1'b0, AW'({thr[SEL_AE_HI], thr[SEL_AE_LO]})};
        used        = wbin - s_d.bin;
        s_d.empty_n = (used != '0);
        s_d.ae_n    = (used > n_ext);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bin     <= '0;
            s_q.gray    <= '0;
            s_q.sel     <= SEL_AE_LO;
            s_q.dout    <= '0;
            s_q.empty_n <= 1'b0;
            s_q.ae_n    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_raddr = s_q.bin[AW-1:0];
    assign rgray     = s_q.gray;
    assign rbin      = s_q.bin;
    assign dout      = s_q.dout;
    assign empty_n   = s_q.empty_n;
    assign ae_n      = s_q.ae_n;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int           DEPTH   = 64,
    parameter int           W       = WORD_W,
    parameter logic [W-1:0] DEF_THR = 7
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    input  logic         rd_en,
    input  logic         rd_en2,
    output logic [W-1:0] dout,
    output logic         empty_n,
    output logic         ae_n,
    output logic         af_n,
    output logic         full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [W-1:0]      mem_rdata;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, wbin, rbin;
    thr_sel_e          wsel;
    logic [3:0][W-1:0] thr;

    pff_wr_side #(.DEPTH(DEPTH), .W(W), .AW(AW), .PW(PW), .DEF_THR(DEF_THR)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .load(load), .wr_en(wr_en), .din(din),
        .rgray_sync(rgray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wgray(wgray), .wbin(wbin), .wsel(wsel), .thr(thr),
        .full_n(full_n), .af_n(af_n)
    );

    pff_rd_side #(.DEPTH(DEPTH), .W(W), .AW(AW), .PW(PW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .load(load), .rd_en(rd_en), .rd_en2(rd_en2),
        .wgray_sync(wgray_s), .thr(thr), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rgray(rgray), .rbin(rbin), .dout(dout),
        .empty_n(empty_n), .ae_n(ae_n)
    );

    pff_mem #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    pff_sync2 #(.WIDTH(PW)) u_sync_w2r (
        .clk(rclk), .rst_n(rst_n), .async_in(wgray), .sync_out(wgray_s)
    );

    pff_sync2 #(.WIDTH(PW)) u_sync_r2w (
        .clk(wclk), .rst_n(rst_n), .async_in(rgray), .sync_out(rgray_s)
    );
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
    parameter int W  = 9,
    parameter int PW = 7
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              load,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_en2,
    input logic [W-1:0]      dout,
    input logic              empty_n,
    input logic              ae_n,
    input logic              af_n,
    input logic              full_n,
    input logic [PW-1:0]     wbin,
    input logic [PW-1:0]     rbin,
    input logic [1:0]        wsel,
    input logic [3:0][W-1:0] thr
);
    assert_no_overflow_R10: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && wr_en && load) |=> (wbin == $past(wbin)));

    assert_no_underflow_R10: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && rd_en && rd_en2 && load) |=> (rbin == $past(rbin) && dout == $past(dout)));

    assert_sel_rotates_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !load) |=> (wsel == $past(wsel) + 2'd1));

    assert_thr_hold_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_en |=> (thr == $past(thr) && wbin == $past(wbin)));

    assert_single_enable_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en != rd_en2) |=> (rbin == $past(rbin) && dout == $past(dout)));

    assert_full_within_af_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !af_n);

    assert_empty_within_ae_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !ae_n);
endmodule

bind prog_flag_fifo pff_checker #(.W(W), .PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load(load), .wr_en(wr_en),
    .rd_en(rd_en), .rd_en2(rd_en2), .dout(dout), .empty_n(empty_n),
    .ae_n(ae_n), .af_n(af_n), .full_n(full_n), .wbin(wbin), .rbin(rbin),
    .wsel(wsel), .thr(thr)
);

// File: tb/prog_flag_fifo_test.sv
`timescale 1ns/1ps
module prog_flag_fifo_test;
    localparam int DEPTH = 64;
    localparam int NVEC  = 14;
    // {target occupancy, empty_n, ae_n, af_n, full_n} with n = m = 7
    localparam logic [10:0] VEC [NVEC] = '{
        {7'd0, 4'b0011}, {7'd1, 4'b1011}, {7'd7, 4'b1011}, {7'd8, 4'b1111},
        {7'd56, 4'b1111}, {7'd57, 4'b1101}, {7'd63, 4'b1101}, {7'd64, 4'b1100},
        {7'd57, 4'b1101}, {7'd56, 4'b1111}, {7'd8, 4'b1111}, {7'd7, 4'b1011},
        {7'd1, 4'b1011}, {7'd0, 4'b0011}
    };

    logic       wclk = 0, rclk = 0, rst_n = 0;
    logic       load = 1, wr_en = 0, rd_en = 0, rd_en2 = 0;
    logic [8:0] din = 0;
    logic [8:0] dout;
    logic       empty_n, ae_n, af_n, full_n;

    int         checks = 0, errors = 0;
    int         occ = 0, thr_n = 7, thr_m = 7;
    logic [8:0] q[$];
    logic [8:0] dgen = 9'd11;
    bit         done = 0;

    prog_flag_fifo uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load(load), .wr_en(wr_en),
        .din(din), .rd_en(rd_en), .rd_en2(rd_en2), .dout(dout),
        .empty_n(empty_n), .ae_n(ae_n), .af_n(af_n), .full_n(full_n)
    );

    always #5 wclk = ~wclk;
    initial begin
        #3;
        forever #5 rclk = ~rclk;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
    endtask

    task automatic wr_word(input logic [8:0] d, input logic ld);
        @(negedge wclk);
        load = ld; wr_en = 1; din = d;
        @(negedge wclk);
        wr_en = 0; load = 1;
    endtask

    task automatic rd_word(output logic [8:0] d, input logic ld, input logic e2);
        @(negedge rclk);
        load = ld; rd_en = 1; rd_en2 = e2;
        @(negedge rclk);
        rd_en = 0; rd_en2 = 0; load = 1;
        d = dout;
    endtask

    function automatic int exp_flags(input int o);
        exp_flags = {o != 0, o > thr_n, !(o >= DEPTH - thr_m), o != DEPTH};
    endfunction

    task automatic check_flags(input int o);
        check($sformatf("R7,R8,R9 flags at occupancy %0d", o),
              {empty_n, ae_n, af_n, full_n}, exp_flags(o));
    endtask

    task automatic step_to(input int target);
        logic [8:0] got;
        while (occ != target) begin
            if (occ < target) begin
                dgen = dgen * 9'd5 + 9'd3;
                wr_word(dgen, 1'b1);
                q.push_back(dgen);
                occ++;
            end else begin
                rd_word(got, 1'b1, 1'b1);
                check("R5 read order", got, q.pop_front());
                occ--;
            end
            settle();
            check_flags(occ);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] got, prev;
        #27 rst_n = 1;
        settle();
        // R1 reset flags and threshold defaults
        check("R1 reset flags", {empty_n, ae_n, af_n, full_n}, 4'b0011);
        rd_word(got, 1'b0, 1'b1); check("R1 R4 default n low", got, 7);
        rd_word(got, 1'b0, 1'b1); check("R1 R4 default n high", got, 0);
        rd_word(got, 1'b0, 1'b1); check("R1 R4 default m low", got, 7);
        rd_word(got, 1'b0, 1'b1); check("R1 R4 default m high", got, 0);

        // Table walk with default thresholds: R5, R7, R8, R9
        for (int v = 0; v < NVEC; v++) begin
            step_to(int'(VEC[v][10:4]));
            check($sformatf("R7 R8 R9 table entry %0d", v),
                  {empty_n, ae_n, af_n, full_n}, int'(VEC[v][3:0]));
            if (occ == DEPTH) begin
                // R10 write while full is dropped
                wr_word(9'h155, 1'b1);
                settle();
                check("R10 full after dropped write", {af_n, full_n}, 2'b00);
            end
        end

        // R10 read while empty: dout held
        prev = dout;
        rd_word(got, 1'b1, 1'b1);
        check("R10 dout held on empty read", got, prev);
        settle();
        check_flags(0);
        wr_word(9'h0A5, 1'b1);
        settle();
        rd_word(got, 1'b1, 1'b1);
        check("R10 read position unmoved", got, 9'h0A5);
        settle();

        // R2 custom thresholds; R3 no write with wr_en low
        wr_word(9'd5, 1'b0);
        wr_word(9'h1C0, 1'b0);
        wr_word(9'd10, 1'b0);
        wr_word(9'h0AB, 1'b0);
        @(negedge wclk);
        load = 0; din = 9'h1FF;
        repeat (3) @(negedge wclk);
        load = 1;
        rd_word(got, 1'b0, 1'b1); check("R2 R3 R4 n low", got, 5);
        rd_word(got, 1'b0, 1'b1); check("R2 R4 n high", got, 9'h1C0);
        rd_word(got, 1'b0, 1'b1); check("R2 R4 m low", got, 10);
        rd_word(got, 1'b0, 1'b1); check("R2 R4 m high", got, 9'h0AB);
        rd_word(got, 1'b0, 1'b1); check("R4 readback wraps", got, 5);

        // R11 high registers ignored at depth 64: n=5, m=10
        thr_n = 5; thr_m = 10;
        settle();
        step_to(5);
        check("R7 R11 ae_n low at n", ae_n, 0);
        step_to(6);
        check("R7 R11 ae_n high at n+1", ae_n, 1);
        step_to(53);
        check("R8 R11 af_n high below depth-m", af_n, 1);
        step_to(54);
        check("R8 R11 af_n low at depth-m", af_n, 0);

        // R6 single read enable has no effect
        prev = dout;
        rd_word(got, 1'b1, 1'b0);
        check("R6 dout unchanged with one enable", got, prev);
        settle();
        check_flags(occ);
        step_to(0);

        // R2 wrap: fifth write lands on n low
        wr_word(9'd3, 1'b0);
        rd_word(got, 1'b0, 1'b1);
        rd_word(got, 1'b0, 1'b1);
        rd_word(got, 1'b0, 1'b1);
        rd_word(got, 1'b0, 1'b1);
        check("R2 write sequence wraps to n low", got, 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule